// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block serves a small bank of general-purpose pins through a simple register bus. Every pin has a group of four 32-bit words. One holds its pad settings, one holds the driven and sampled levels, one sets up interrupt detection and routing, and one holds the latched status bit. The pad controls for pull, alternate function and drive strength are only stored and exported as wires. The output value and output enable drive the pad directly. Each pad input goes through a two-flop synchronizer before software or the detector sees it.

Each pin watches its synchronized input for a level, a rising edge, a falling edge or either edge, and a polarity bit can invert the sense. A detected event can do two things, and each has its own gate. It can latch the readable status bit, and it can raise the pin's interrupt. An interrupt can therefore fire while the status stays clear, and the status can latch while no interrupt is raised. A 3-bit target field steers each pin's interrupt onto one of several processor lines. The code 7 sends it nowhere.

Top module: `gpioic_top`

## Requirements
- R1: Pin p's word group starts at byte address 16·p (p = bus_addr[ADDR_W-1:4]). The words are pad settings at +0x0, levels at +0x4, interrupt setup at +0x8 and status at +0xC. Read data and bus_rvalid appear on the cycle after the read request.
- R2: After reset, every pad-settings word, level word and status word reads 0, every interrupt setup word reads 0x0E0 (target 7), and pad_out, pad_oe, pin_irq and tgt_irq are all 0.
- R3: In the pad-settings word, bits 1:0 are pull, bits 5:2 are function, bits 8:6 are drive strength and bit 9 is output enable. These fields drive pad_pull, pad_func, pad_drv and pad_oe. Bits above 9 read as 0.
- R4: In the level word, bit 1 is the stored output value driving pad_out. Bit 0 reads the pad input after two register stages, so a read issued at the first clock edge after a pad change still returns the old level.
- R5: The interrupt setup word has these fields: bit 0 is interrupt enable, bit 1 is polarity (1 = high/rising), bits 3:2 are the detection type, bit 4 is status enable, bits 7:5 are the target and bit 8 is a stored direct-connect flag. With detection type 0 (level), a pin triggers on every cycle in which its synchronized level equals the polarity, so a cleared status is set again while that level persists.
- R6: With detection type 1, a rising edge of the synchronized input triggers when polarity is 1, and a falling edge triggers when polarity is 0. A level that stays put does not trigger again.
- R7: With detection type 2 and polarity 1, only a falling edge of the synchronized input triggers.
- R8: With detection type 3, both edges trigger.
- R9: A trigger sets the status bit only when status enable is 1. It sets the pin's pending interrupt only when interrupt enable is 1. pin_irq is interrupt enable AND pending. The two gates act independently.
- R10: A write to the status word with bit 0 = 0 clears both the status bit and the pending interrupt. A write with bit 0 = 1 changes nothing. A trigger in the same cycle takes precedence over the clear.
- R11: tgt_irq[t] is the OR of pin_irq over the pins whose target equals t. A pin with target 7, or with a target of N_TGT or more, drives no line.
- R12: Addresses whose pin index is N_PINS or more read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | N_PINS | Raw pad inputs |
| pad_out | output | N_PINS | Driven output values |
| pad_oe | output | N_PINS | Output enables |
| pad_pull | output | 2·N_PINS | Pull select per pin |
| pad_func | output | 4·N_PINS | Function select per pin |
| pad_drv | output | 3·N_PINS | Drive strength per pin |
| pin_irq | output | N_PINS | Per-pin interrupt |
| tgt_irq | output | N_TGT | Per-processor interrupt lines |

## Verification
The bench builds the block with N_PINS = 4, N_TGT = 4 and ADDR_W = 8. With these values every pin can be given its own target line, so a wrong routing shows up as a wrong bit pattern on tgt_irq. The target code 5 is a valid field value but has no line, so it exercises the out-of-range routing case. The 8-bit address also leaves pin indices 4 to 15 unmapped, so reads and writes outside the bank can be tested.

// File: rtl/gpioic_pkg.sv
package gpioic_pkg;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_e;

  typedef enum logic [1:0] {
    OFS_PAD  = 2'd0,
    OFS_LVL  = 2'd1,
    OFS_ICFG = 2'd2,
    OFS_STAT = 2'd3
  } ofs_e;

  // Pad settings word, bits 9:0
  typedef struct packed {
    logic       oe;
    logic [2:0] drv;
    logic [3:0] func;
    logic [1:0] pull;
  } padcfg_t;

  // Interrupt setup word, bits 8:0
  typedef struct packed {
    logic       dconn;
    logic [2:0] tgt;
    logic       stat_en;
    det_e       det;
    logic       pol;
    logic       en;
  } icfg_t;

  localparam logic [2:0] TGT_NONE = 3'd7;
  localparam logic [8:0] ICFG_RST = {1'b0, TGT_NONE, 1'b0, 2'd0, 1'b0, 1'b0};

  // Trigger evaluation: both samples are seen through the polarity first.
  function automatic logic det_fire(det_e det, logic pol, logic cur, logic prv);
    logic a;
    logic b;
    a = pol ? cur : ~cur;
    b = pol ? prv : ~prv;
    case (det)
      DET_LEVEL: det_fire = a;
      DET_RISE:  det_fire = a & ~b;
      DET_FALL:  det_fire = ~a & b;
      default:   det_fire = a ^ b;
    endcase
  endfunction

  function automatic logic tgt_hits(logic [2:0] tgt, logic [2:0] line);
    tgt_hits = (tgt != TGT_NONE) && (tgt == line);
  endfunction

endpackage

// File: rtl/gpioic_sync.sv
module gpioic_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpioic_pin.sv
module gpioic_pin
  import gpioic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pad_s,
  input  logic        wr_en,
  input  ofs_e        wr_ofs,
  input  logic [31:0] wr_data,
  input  ofs_e        rd_ofs,
  output logic [31:0] rd_word,
  output padcfg_t     padcfg,
  output logic        out_val,
  output icfg_t       icfg,
  output logic        status,
  output logic        trig,
  output logic        clr,
  output logic        irq
);
  logic prev;
  logic pending;

  assign trig = det_fire(icfg.det, icfg.pol, pad_s, prev);
  assign clr  = wr_en && (wr_ofs == OFS_STAT) && !wr_data[0];
  assign irq  = icfg.en & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      padcfg  <= '0;
      out_val <= 1'b0;
      icfg    <= icfg_t'(ICFG_RST);
    end else begin
      prev <= pad_s;
      if (wr_en && wr_ofs == OFS_PAD)  padcfg  <= padcfg_t'(wr_data[9:0]);
      if (wr_en && wr_ofs == OFS_LVL)  out_val <= wr_data[1];
      if (wr_en && wr_ofs == OFS_ICFG) icfg    <= icfg_t'(wr_data[8:0]);
    end
  end

  // Status latch and pending interrupt are gated separately.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (trig && icfg.stat_en) status <= 1'b1;
      else if (clr)             status <= 1'b0;
      if (trig && icfg.en)      pending <= 1'b1;
      else if (clr)             pending <= 1'b0;
    end
  end

  always_comb begin
    case (rd_ofs)
      OFS_PAD:  rd_word = {22'd0, padcfg};
      OFS_LVL:  rd_word = {30'd0, out_val, pad_s};
      OFS_ICFG: rd_word = {23'd0, icfg};
      default:  rd_word = {31'd0, status};
    endcase
  end
endmodule

// File: rtl/gpioic_route.sv
module gpioic_route
  import gpioic_pkg::*;
#(
  parameter int N_PINS = 4,
  parameter int N_TGT  = 4
) (
  input  logic [N_PINS-1:0]   irq,
  input  logic [3*N_PINS-1:0] tgt,
  output logic [N_TGT-1:0]    line
);
  for (genvar t = 0; t < N_TGT; t++) begin : g_line
    always_comb begin
      line[t] = 1'b0;
      for (int p = 0; p < N_PINS; p++) begin
        if (irq[p] && tgt_hits(tgt[3*p +: 3], 3'(t))) line[t] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpioic_top.sv
module gpioic_top
  import gpioic_pkg::*;
#(
  parameter int N_PINS = 4,
  parameter int N_TGT  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [N_PINS-1:0]   pad_in,
  output logic [N_PINS-1:0]   pad_out,
  output logic [N_PINS-1:0]   pad_oe,
  output logic [2*N_PINS-1:0] pad_pull,
  output logic [4*N_PINS-1:0] pad_func,
  output logic [3*N_PINS-1:0] pad_drv,
  output logic [N_PINS-1:0]   pin_irq,
  output logic [N_TGT-1:0]    tgt_irq
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]    pin_idx;
  ofs_e                ofs;
  logic                hit;
  logic [N_PINS-1:0]   pad_s;
  logic [N_PINS-1:0]   pin_trig;
  logic [N_PINS-1:0]   pin_clr;
  logic [N_PINS-1:0]   pin_stat;
  logic [N_PINS-1:0]   pin_rse;
  logic [N_PINS-1:0]   pin_en;
  logic [3*N_PINS-1:0] pin_tgt;
  logic [31:0]         rd_words [N_PINS];
  logic [31:0]         rd_mux;

  assign pin_idx = bus_addr[ADDR_W-1:4];
  assign ofs     = ofs_e'(bus_addr[3:2]);
  assign hit     = (32'(pin_idx) < N_PINS);

  gpioic_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    padcfg_t pc;
    icfg_t   ic;
    logic    wen;

    assign wen = bus_sel && bus_wr && hit && (32'(pin_idx) == i);

    gpioic_pin u_pin (
      .clk(clk), .rst_n(rst_n), .pad_s(pad_s[i]),
      .wr_en(wen), .wr_ofs(ofs), .wr_data(bus_wdata),
      .rd_ofs(ofs), .rd_word(rd_words[i]),
      .padcfg(pc), .out_val(pad_out[i]), .icfg(ic),
      .status(pin_stat[i]), .trig(pin_trig[i]), .clr(pin_clr[i]),
      .irq(pin_irq[i])
    );

    assign pad_oe[i]           = pc.oe;
    assign pad_pull[2*i +: 2]  = pc.pull;
    assign pad_func[4*i +: 4]  = pc.func;
    assign pad_drv[3*i +: 3]   = pc.drv;
    assign pin_tgt[3*i +: 3]   = ic.tgt;
    assign pin_rse[i]          = ic.stat_en;
    assign pin_en[i]           = ic.en;
  end

  gpioic_route #(.N_PINS(N_PINS), .N_TGT(N_TGT)) u_route (
    .irq(pin_irq), .tgt(pin_tgt), .line(tgt_irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_PINS; i++) begin
      if (hit && 32'(pin_idx) == i) rd_mux = rd_words[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpioic_chk.sv
module gpioic_chk #(
  parameter int N_PINS = 4,
  parameter int N_TGT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_rvalid,
  input logic [N_PINS-1:0] pin_trig,
  input logic [N_PINS-1:0] pin_clr,
  input logic [N_PINS-1:0] pin_stat,
  input logic [N_PINS-1:0] pin_rse,
  input logic [N_PINS-1:0] pin_en,
  input logic [N_PINS-1:0] pin_irq,
  input logic [N_TGT-1:0]  tgt_irq
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    assert_stat_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_stat[i]) |-> $past(pin_trig[i] && pin_rse[i]));
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pin_irq[i] |-> pin_en[i]);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_clr[i] && !pin_trig[i]) |=> !pin_stat[i]);
  end

  assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_irq == '0) |-> (tgt_irq == '0));
  assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);
  assert_rvalid_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_sel && !bus_wr));
endmodule

bind gpioic_top gpioic_chk #(.N_PINS(N_PINS), .N_TGT(N_TGT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rvalid(bus_rvalid), .pin_trig(pin_trig), .pin_clr(pin_clr),
  .pin_stat(pin_stat), .pin_rse(pin_rse), .pin_en(pin_en),
  .pin_irq(pin_irq), .tgt_irq(tgt_irq)
);

// File: tb/gpioic_top_tb.sv
`timescale 1ns/1ps
module gpioic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  pad_in = '0;
  logic [3:0]  pad_out, pad_oe, pin_irq, tgt_irq;
  logic [7:0]  pad_pull;
  logic [15:0] pad_func;
  logic [11:0] pad_drv;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpioic_top #(.N_PINS(4), .N_TGT(4), .ADDR_W(8)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ad(input int pin, input int ofs);
    return 8'(pin * 16 + ofs);
  endfunction

  function automatic logic [31:0] icw(input logic en, input logic pol, input logic [1:0] typ,
                                      input logic rse, input logic [2:0] tgt);
    return {23'd0, 1'b0, tgt, rse, typ, pol, en};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R1 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic pad(input int p, input logic v);
    @(negedge clk);
    pad_in[p] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic park(input int p);
    wr(ad(p, 8), 32'h0E0);
    wr(ad(p, 12), 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(ad(0, 0), d);  chk("R2 pad word", d, 0);
    rd(ad(1, 8), d);  chk("R2 icfg word", d, 32'h0E0);
    rd(ad(3, 12), d); chk("R2 status", d, 0);
    rd(ad(2, 4), d);  chk("R2 level word", d, 0);
    chk("R2 outputs", {pad_out, pad_oe, pin_irq, tgt_irq}, 0);
  endtask

  task automatic t_padcfg;
    logic [31:0] d;
    wr(ad(2, 0), 32'hFFFF_FFFF);
    rd(ad(2, 0), d); chk("R3 upper bits zero", d, 32'h3FF);
    chk("R3 pull pin2", pad_pull[5:4], 3);
    wr(ad(1, 0), 32'h36A);
    @(negedge clk);
    chk("R3 func pin1", pad_func[7:4], 4'hA);
    chk("R3 drv pin1", pad_drv[5:3], 5);
    chk("R3 pull pin1", pad_pull[3:2], 2);
    chk("R3 oe", pad_oe, 4'b0110);
  endtask

  task automatic t_level_io;
    logic [31:0] d;
    wr(ad(1, 4), 32'h2);
    chk("R4 pad_out", pad_out, 4'b0010);
    pad(1, 1'b1);
    rd(ad(1, 4), d); chk("R4 two-stage delay", d, 32'h2);
    rd(ad(1, 4), d); chk("R4 sampled level", d, 32'h3);
    wr(ad(1, 4), 32'h0);
    chk("R4 pad_out low", pad_out, 0);
    pad(1, 1'b0);
    idle(3);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(ad(0, 8), icw(1, 1, 0, 1, 0));
    wr(ad(0, 12), 0);
    rd(ad(0, 12), d); chk("R5 low idle", d, 0);
    pad(0, 1'b1); idle(3);
    rd(ad(0, 12), d); chk("R5 level high", d, 1);
    chk("R5 line0", tgt_irq, 4'b0001);
    wr(ad(0, 12), 0);
    rd(ad(0, 12), d); chk("R5 re-set while held", d, 1);
    pad(0, 1'b0); idle(3);
    wr(ad(0, 12), 0);
    rd(ad(0, 12), d); chk("R5 cleared when low", d, 0);
    chk("R5 line idle", tgt_irq, 0);
    wr(ad(0, 8), icw(1, 0, 0, 1, 0)); idle(2);
    rd(ad(0, 12), d); chk("R5 active-low level", d, 1);
    park(0);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    wr(ad(1, 8), icw(1, 1, 1, 1, 1));
    wr(ad(1, 12), 0);
    rd(ad(1, 12), d); chk("R6 idle", d, 0);
    pad(1, 1'b1); idle(3);
    rd(ad(1, 12), d); chk("R6 rising", d, 1);
    chk("R6 line1", tgt_irq, 4'b0010);
    wr(ad(1, 12), 0); idle(2);
    rd(ad(1, 12), d); chk("R6 no re-set on steady high", d, 0);
    chk("R6 line cleared", tgt_irq, 0);
    pad(1, 1'b0); idle(3);
    rd(ad(1, 12), d); chk("R6 falling ignored", d, 0);
    wr(ad(1, 8), icw(1, 0, 1, 1, 1));
    pad(1, 1'b1); idle(3);
    rd(ad(1, 12), d); chk("R6 inverted ignores rise", d, 0);
    pad(1, 1'b0); idle(3);
    rd(ad(1, 12), d); chk("R6 inverted falling", d, 1);
    park(1);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr(ad(2, 8), icw(1, 1, 2, 1, 2));
    pad(2, 1'b1); idle(3);
    wr(ad(2, 12), 0);
    rd(ad(2, 12), d); chk("R7 rise ignored", d, 0);
    pad(2, 1'b0); idle(3);
    rd(ad(2, 12), d); chk("R7 falling", d, 1);
    chk("R7 line2", tgt_irq, 4'b0100);
    park(2);
  endtask

  task automatic t_both;
    logic [31:0] d;
    wr(ad(3, 8), icw(1, 1, 3, 1, 3));
    wr(ad(3, 12), 0);
    pad(3, 1'b1); idle(3);
    rd(ad(3, 12), d); chk("R8 rise", d, 1);
    wr(ad(3, 12), 0);
    pad(3, 1'b0); idle(3);
    rd(ad(3, 12), d); chk("R8 fall", d, 1);
    chk("R8 line3", tgt_irq, 4'b1000);
    wr(ad(3, 12), 0); idle(2);
    rd(ad(3, 12), d); chk("R8 steady", d, 0);
    park(3);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(ad(0, 8), icw(1, 1, 0, 0, 0));
    pad(0, 1'b1); idle(3);
    chk("R9 irq without status", tgt_irq, 4'b0001);
    rd(ad(0, 12), d); chk("R9 status stays clear", d, 0);
    wr(ad(0, 8), icw(0, 1, 0, 1, 0));
    wr(ad(0, 12), 0); idle(2);
    rd(ad(0, 12), d); chk("R9 status without irq", d, 1);
    chk("R9 irq masked", pin_irq, 0);
    pad(0, 1'b0); idle(3);
    park(0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(ad(1, 8), icw(1, 1, 1, 1, 1));
    pad(1, 1'b1); idle(3);
    wr(ad(1, 12), 32'h1);
    rd(ad(1, 12), d); chk("R10 write one ignored", d, 1);
    chk("R10 irq kept", pin_irq, 4'b0010);
    wr(ad(1, 12), 32'h0);
    rd(ad(1, 12), d); chk("R10 write zero clears", d, 0);
    chk("R10 irq cleared", pin_irq, 0);
    pad(1, 1'b0); idle(3);
    park(1);
  endtask

  task automatic t_route;
    logic [31:0] d;
    wr(ad(0, 8), icw(1, 1, 0, 1, 2));
    pad(0, 1'b1); idle(3);
    chk("R11 target 2", tgt_irq, 4'b0100);
    wr(ad(0, 8), icw(1, 1, 0, 1, 7)); @(negedge clk);
    chk("R11 target none", tgt_irq, 0);
    chk("R11 pin still raised", pin_irq, 4'b0001);
    wr(ad(0, 8), icw(1, 1, 0, 1, 5)); @(negedge clk);
    chk("R11 target beyond lines", tgt_irq, 0);
    wr(ad(0, 8), icw(1, 1, 0, 1, 3)); @(negedge clk);
    chk("R11 target 3", tgt_irq, 4'b1000);
    pad(0, 1'b0); idle(3);
    park(0);
    rd(ad(0, 12), d); chk("R11 parked", d, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R12 read zero", d, 0);
    rd(8'h48, d); chk("R12 read zero icfg slot", d, 0);
    rd(ad(0, 0), d); chk("R12 pin0 untouched", d, 0);
    rd(ad(0, 8), d); chk("R12 pin0 icfg untouched", d, 32'h0E0);
    chk("R12 oe untouched", pad_oe, 4'b0110);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_padcfg();
    t_level_io();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_gate();
    t_clear();
    t_route();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule